// File: doc/BRIEF.md
# OFDM Cyclic Prefix Frame Link

This block frames one 8-point IFFT result for transmission and recovers it on the far side. On the transmit half, a 128-bit real vector and a 128-bit imaginary vector are accepted through a load/ready handshake. The block appends a prefix made of the low 48 bits of the imaginary vector, which gives a 304-bit frame. It then shifts that frame out as nineteen 16-bit words, most significant word first, on consecutive cycles with a word-valid flag.

The receive half is independent. It counts incoming valid words and packs the first sixteen into the real and imaginary vectors. It drops the three trailing prefix words. After the nineteenth word it raises a one-cycle valid pulse, and the rebuilt vectors stay on its outputs until the next frame completes.

A new frame may be loaded in the cycle that presents the last word of the current one. The stream then runs without a gap between frames.

Top module: `cp_link`

## Requirements
- R1: During and after reset: `tx_vld_o` is 0, `ld_ready_o` is 1, `rx_vld_o` is 0, and `rx_re_o` and `rx_im_o` are 0.
- R2: A load is taken on a clock edge where both `ld_i` and `ld_ready_o` are 1. The first word of that frame appears on `tx_word_o`, with `tx_vld_o` at 1, in the cycle that follows the edge.
- R3: The frame from the top down is re[127:0], im[127:0], im[47:0]. It leaves as 19 words on 19 consecutive cycles with `tx_vld_o` at 1. Word k (k = 0..18) is frame bits [303-16k : 288-16k]. After the last word, `tx_vld_o` returns to 0 unless a new load was taken.
- R4: `ld_ready_o` is 1 when no frame is streaming and in the cycle that presents word 18. It is 0 in every other streaming cycle. While it is 0, `ld_i` has no effect on the words sent or on the frame length.
- R5: A load taken in the cycle that presents word 18 makes word 0 of the new frame appear in the very next cycle, with no idle cycle between the frames.
- R6: On the receive side, valid words 0..7 fill `rx_re_o` most significant word first, and valid words 8..15 fill `rx_im_o` the same way. `rx_vld_o` is 1 for exactly one cycle, the cycle after the edge that accepts word 18.
- R7: The contents of received words 16..18 (the prefix) have no effect on `rx_re_o` or `rx_im_o`.
- R8: Cycles with `rx_vld_i` at 0 neither advance the receive word count nor change anything. `rx_re_o` and `rx_im_o` hold their values in every cycle in which `rx_vld_o` is 0.
- R9: When `tx_word_o` and `tx_vld_o` are looped into `rx_word_i` and `rx_vld_i`, the vectors that are rebuilt equal the loaded vectors bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_i | input | 1 | Load request for a new frame |
| re_i | input | 128 | Real IFFT vector to send |
| im_i | input | 128 | Imaginary IFFT vector to send |
| ld_ready_o | output | 1 | Transmit side can take a load this cycle |
| tx_word_o | output | 16 | Outgoing frame word |
| tx_vld_o | output | 1 | Outgoing word is valid |
| rx_word_i | input | 16 | Incoming frame word |
| rx_vld_i | input | 1 | Incoming word is valid |
| rx_re_o | output | 128 | Rebuilt real vector |
| rx_im_o | output | 128 | Rebuilt imaginary vector |
| rx_vld_o | output | 1 | One-cycle pulse: rebuilt vectors are new |

## Verification
A wrong transmit count or shift state shows at the ports within one frame, at most 19 cycles. It appears as a wrong word on a known index, a frame that is too short or too long, or a ready flag in the wrong cycle. A load that slips through while busy corrupts the very next word. On the receive side, an off-by-one word counter shows up at the next valid pulse. The pulse either lands one word early or late, or real data comes out shifted by one word. The prefix-corruption and gapped-stream tests catch a counter that counts idle cycles or that packs prefix words into the vectors.

// File: rtl/cp_pkg.sv
package cp_pkg;
    localparam int unsigned CP_SAMPLE_W     = 16;
    localparam int unsigned CP_POINTS       = 8;
    localparam int unsigned CP_PREFIX_WORDS = 3;

    function automatic int unsigned cp_frame_words(int unsigned points, int unsigned prefix);
        return 2 * points + prefix;
    endfunction
endpackage

// File: rtl/cp_frame_builder.sv
module cp_frame_builder #(
    parameter int unsigned SAMPLE_W     = cp_pkg::CP_SAMPLE_W,
    parameter int unsigned POINTS       = cp_pkg::CP_POINTS,
    parameter int unsigned PREFIX_WORDS = cp_pkg::CP_PREFIX_WORDS,
    localparam int unsigned VEC_W       = SAMPLE_W * POINTS,
    localparam int unsigned PREFIX_W    = SAMPLE_W * PREFIX_WORDS,
    localparam int unsigned FRAME_W     = 2 * VEC_W + PREFIX_W
) (
    input  logic [VEC_W-1:0]   re_i,
    input  logic [VEC_W-1:0]   im_i,
    output logic [FRAME_W-1:0] frame_o
);
    generate
        if (PREFIX_WORDS == 0) begin : g_no_prefix
            assign frame_o = {re_i, im_i};
        end else begin : g_prefix
            // prefix repeats the low end of the imaginary vector
            assign frame_o = {re_i, im_i, im_i[PREFIX_W-1:0]};
        end
    endgenerate
endmodule

// File: rtl/cp_serializer.sv
module cp_serializer #(
    parameter int unsigned SAMPLE_W     = cp_pkg::CP_SAMPLE_W,
    parameter int unsigned POINTS       = cp_pkg::CP_POINTS,
    parameter int unsigned PREFIX_WORDS = cp_pkg::CP_PREFIX_WORDS,
    localparam int unsigned VEC_W       = SAMPLE_W * POINTS,
    localparam int unsigned FRAME_W     = 2 * VEC_W + SAMPLE_W * PREFIX_WORDS,
    localparam int unsigned N_WORDS     = cp_pkg::cp_frame_words(POINTS, PREFIX_WORDS),
    localparam int unsigned CNT_W       = $clog2(N_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_i,
    input  logic [FRAME_W-1:0]  frame_i,
    output logic                ld_ready_o,
    output logic [SAMPLE_W-1:0] word_o,
    output logic                vld_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   left;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        take = ld_i && ld_ready_o;
        if (st_q.left != '0) begin
            st_d.shreg = st_q.shreg << SAMPLE_W;
            st_d.left  = st_q.left - CNT_W'(1);
        end
        if (take) begin
            st_d.shreg = frame_i;
            st_d.left  = CNT_W'(N_WORDS);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_ready_o = (st_q.left <= CNT_W'(1));
    assign vld_o      = (st_q.left != '0);
    assign word_o     = st_q.shreg[FRAME_W-1 -: SAMPLE_W];

    // R2: an accepted load starts streaming on the next cycle
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && ld_ready_o) |=> vld_o);

    // R3: mid-frame the stream never breaks
    a_r3_no_break: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !ld_ready_o) |=> vld_o);

    // R3: next word is the one that sat below the current one
    a_r3_word_order: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && !ld_ready_o) |=> (word_o == $past(st_q.shreg[FRAME_W-SAMPLE_W-1 -: SAMPLE_W])));

    // R4: idle transmitter always accepts
    a_r4_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> ld_ready_o);

    // R5: back-to-back load presents the new frame head immediately
    a_r5_gapless: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && ld_ready_o && vld_o) |=> (vld_o && word_o == $past(frame_i[FRAME_W-1 -: SAMPLE_W])));
endmodule

// File: rtl/cp_deserializer.sv
module cp_deserializer #(
    parameter int unsigned SAMPLE_W     = cp_pkg::CP_SAMPLE_W,
    parameter int unsigned POINTS       = cp_pkg::CP_POINTS,
    parameter int unsigned PREFIX_WORDS = cp_pkg::CP_PREFIX_WORDS,
    localparam int unsigned VEC_W       = SAMPLE_W * POINTS,
    localparam int unsigned BODY_W      = 2 * VEC_W,
    localparam int unsigned BODY_WORDS  = 2 * POINTS,
    localparam int unsigned N_WORDS     = cp_pkg::cp_frame_words(POINTS, PREFIX_WORDS),
    localparam int unsigned CNT_W       = $clog2(N_WORDS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] word_i,
    input  logic                word_vld_i,
    output logic [VEC_W-1:0]    re_o,
    output logic [VEC_W-1:0]    im_o,
    output logic                vld_o
);
    typedef struct packed {
        logic [BODY_W-1:0] body;
        logic [CNT_W-1:0]  idx;
        logic [VEC_W-1:0]  re;
        logic [VEC_W-1:0]  im;
        logic              vld;
    } des_st_t;

    des_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (word_vld_i) begin
            if (st_q.idx < CNT_W'(BODY_WORDS)) begin
                st_d.body = {st_q.body[BODY_W-SAMPLE_W-1:0], word_i};
            end
            if (st_q.idx == CNT_W'(N_WORDS - 1)) begin
                st_d.idx = '0;
                st_d.re  = st_d.body[BODY_W-1:VEC_W];
                st_d.im  = st_d.body[VEC_W-1:0];
                st_d.vld = 1'b1;
            end else begin
                st_d.idx = st_q.idx + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign re_o  = st_q.re;
    assign im_o  = st_q.im;
    assign vld_o = st_q.vld;

    // R6: frame completion is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |=> !vld_o);

    // R8: idle input cycles leave the word count alone
    a_r8_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_i |=> $stable(st_q.idx));

    // R8: rebuilt vectors only move together with the pulse
    a_r8_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_o |-> ($stable(re_o) && $stable(im_o)));
endmodule

// File: rtl/cp_link.sv
module cp_link (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_i,
    input  logic [127:0] re_i,
    input  logic [127:0] im_i,
    output logic         ld_ready_o,
    output logic [15:0]  tx_word_o,
    output logic         tx_vld_o,
    input  logic [15:0]  rx_word_i,
    input  logic         rx_vld_i,
    output logic [127:0] rx_re_o,
    output logic [127:0] rx_im_o,
    output logic         rx_vld_o
);
    localparam int unsigned SAMPLE_W = cp_pkg::CP_SAMPLE_W;
    localparam int unsigned POINTS   = cp_pkg::CP_POINTS;
    localparam int unsigned PREFIX   = cp_pkg::CP_PREFIX_WORDS;
    localparam int unsigned FRAME_W  = 2 * SAMPLE_W * POINTS + SAMPLE_W * PREFIX;

    logic [FRAME_W-1:0] frame_w;

    cp_frame_builder #(.SAMPLE_W(SAMPLE_W), .POINTS(POINTS), .PREFIX_WORDS(PREFIX)) u_build (
        .re_i    (re_i),
        .im_i    (im_i),
        .frame_o (frame_w)
    );

    cp_serializer #(.SAMPLE_W(SAMPLE_W), .POINTS(POINTS), .PREFIX_WORDS(PREFIX)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_i       (ld_i),
        .frame_i    (frame_w),
        .ld_ready_o (ld_ready_o),
        .word_o     (tx_word_o),
        .vld_o      (tx_vld_o)
    );

    cp_deserializer #(.SAMPLE_W(SAMPLE_W), .POINTS(POINTS), .PREFIX_WORDS(PREFIX)) u_des (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_i     (rx_word_i),
        .word_vld_i (rx_vld_i),
        .re_o       (rx_re_o),
        .im_o       (rx_im_o),
        .vld_o      (rx_vld_o)
    );
endmodule

// File: tb/cp_link_tb_top.sv
module cp_link_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld = 1'b0;
    logic [127:0] re_in = '0, im_in = '0;
    logic         ready, tx_vld, rx_vld_in, rx_vld;
    logic [15:0]  tx_word, rx_word;
    logic [127:0] rx_re, rx_im;
    logic         loop_en = 1'b0;
    logic [15:0]  drv_word = '0;
    logic         drv_vld = 1'b0;
    int           n_chk = 0, n_bad = 0;

    always #10 clk = ~clk;

    assign rx_word   = loop_en ? tx_word : drv_word;
    assign rx_vld_in = loop_en ? tx_vld  : drv_vld;

    cp_link dut_i (
        .clk(clk), .rst_n(rst_n), .ld_i(ld), .re_i(re_in), .im_i(im_in),
        .ld_ready_o(ready), .tx_word_o(tx_word), .tx_vld_o(tx_vld),
        .rx_word_i(rx_word), .rx_vld_i(rx_vld_in),
        .rx_re_o(rx_re), .rx_im_o(rx_im), .rx_vld_o(rx_vld)
    );

    function automatic logic [15:0] word_of(logic [127:0] re, logic [127:0] im, int k);
        logic [303:0] f;
        f = {re, im, im[47:0]};
        return f[303-16*k -: 16];
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 tx_vld in reset", 128'(tx_vld), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 tx_vld", 128'(tx_vld), 128'(0));
        chk("R1 ready", 128'(ready), 128'(1));
        chk("R1 rx_vld", 128'(rx_vld), 128'(0));
        chk("R1 rx_re", rx_re, '0);
        chk("R1 rx_im", rx_im, '0);
    endtask

    task automatic t_layout(logic [127:0] re, logic [127:0] im);
        @(negedge clk);
        ld = 1'b1; re_in = re; im_in = im;
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (k == 0) ld = 1'b0;
            chk("R2/R3 tx_vld", 128'(tx_vld), 128'(1));
            chk("R3 word", 128'(tx_word), 128'(word_of(re, im, k)));
            chk("R4 ready", 128'(ready), 128'(k == 18));
        end
        @(negedge clk);
        chk("R3 end of frame", 128'(tx_vld), 128'(0));
    endtask

    task automatic t_busy(logic [127:0] re, logic [127:0] im);
        @(negedge clk);
        ld = 1'b1; re_in = re; im_in = im;
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (k == 0) ld = 1'b0;
            chk("R4 word under busy load", 128'(tx_word), 128'(word_of(re, im, k)));
            if (k == 5) begin ld = 1'b1; re_in = ~re; im_in = ~im; end
            if (k == 6) ld = 1'b0;
        end
        @(negedge clk);
        chk("R4 ignored load left no frame", 128'(tx_vld), 128'(0));
    endtask

    task automatic t_back2back(logic [127:0] ra, logic [127:0] ia, logic [127:0] rb, logic [127:0] ib);
        @(negedge clk);
        ld = 1'b1; re_in = ra; im_in = ia;
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (k == 0) ld = 1'b0;
            chk("R5 first frame word", 128'(tx_word), 128'(word_of(ra, ia, k)));
            if (k == 18) begin ld = 1'b1; re_in = rb; im_in = ib; end
        end
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (k == 0) ld = 1'b0;
            chk("R5 second frame vld", 128'(tx_vld), 128'(1));
            chk("R5 second frame word", 128'(tx_word), 128'(word_of(rb, ib, k)));
        end
        @(negedge clk);
        chk("R5 stream ends", 128'(tx_vld), 128'(0));
    endtask

    task automatic t_rx_gaps(logic [127:0] re, logic [127:0] im);
        logic [127:0] prev_re, prev_im;
        prev_re = rx_re; prev_im = rx_im;
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            drv_vld  = 1'b1;
            drv_word = (k < 16) ? word_of(re, im, k) : 16'($urandom());
            @(negedge clk);
            drv_vld = 1'b0;
            if (k < 18) begin
                chk("R8 no early pulse", 128'(rx_vld), 128'(0));
                chk("R8 re held", rx_re, prev_re);
                chk("R8 im held", rx_im, prev_im);
            end else begin
                chk("R6 pulse", 128'(rx_vld), 128'(1));
                chk("R6/R7 rx_re", rx_re, re);
                chk("R6/R7 rx_im", rx_im, im);
            end
            repeat (2) @(negedge clk);
            if (k < 18) chk("R8 gap no pulse", 128'(rx_vld), 128'(0));
        end
        chk("R6 single pulse", 128'(rx_vld), 128'(0));
    endtask

    task automatic t_roundtrip(logic [127:0] re, logic [127:0] im);
        loop_en = 1'b1;
        @(negedge clk);
        ld = 1'b1; re_in = re; im_in = im;
        for (int k = 0; k < 19; k++) begin
            @(negedge clk);
            if (k == 0) ld = 1'b0;
            if (k == 18) chk("R9 no pulse yet", 128'(rx_vld), 128'(0));
        end
        @(negedge clk);
        chk("R9 pulse", 128'(rx_vld), 128'(1));
        chk("R9 re round trip", rx_re, re);
        chk("R9 im round trip", rx_im, im);
        loop_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=hung exp=done");
        report();
        $finish;
    end

    initial begin
        logic [127:0] r0, i0;
        t_reset();
        t_layout({8{16'h1234}} ^ 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210,
                 128'hdead_beef_0000_ffff_a5a5_5a5a_1111_2222);
        t_layout('1, '0);
        t_busy(rnd128(), rnd128());
        t_back2back(rnd128(), rnd128(), rnd128(), rnd128());
        r0 = rnd128(); i0 = rnd128();
        t_rx_gaps(r0, i0);
        t_rx_gaps(r0, i0);
        t_rx_gaps(rnd128(), rnd128());
        for (int n = 0; n < 4; n++) t_roundtrip(rnd128(), rnd128());
        report();
        $finish;
    end
endmodule